// File: doc/BRIEF.md
# SPI Link Watchdog Timers

This block supervises the activity of an SPI slave link using two independent timers. Both count a shared microsecond tick that is derived from the system clock. The first is the serial-clock timer. While chip select is asserted, it waits for the serial clock. If no clock edge arrives within its configured window, it pulses a reset to the SPI shift logic and sets a sticky timeout flag. The second is the link watchdog. It waits for frames that complete with a valid CRC. If none arrives within its window, it pulses a request that moves the device into its fail-safe state.

The block also watches how each command ends. If chip select goes inactive after a command has started (at least one serial clock edge) but before the command has been fully received, a sticky chip-select error flag is set. The link side supplies single-cycle pulses that are already synchronised to the system clock. These pulses mark serial clock edges, completed commands and CRC-valid frames. The configuration fields arrive from a register file elsewhere in the design.

Both timeout tables are built from one scaling parameter: the number of ticks per millisecond. A bench can therefore shrink every timeout by the same factor without changing how the fields are decoded.

Top module: `spi_link_wdog`

## Requirements
- R1: When `rst_tmo_cfg_i` is 0, the serial-clock timer is off. `spi_reset_o` never pulses and `tmo_flag_o` is never set by it.
- R2: With `rst_tmo_cfg_i` not 0, chip select active and no serial clock edge, `spi_reset_o` pulses once for one cycle after the window the setting selects. The settings map as follows:
  - 1 = 0.5 ms, 2 = 1 ms, 3 = 2 ms, 4 = 3 ms, 5 = 4 ms, 6 = 5 ms, 7 = 10 ms
  - 8 = 15 ms, 9 = 20 ms, 10 = 30 ms, 11 = 40 ms, 12 = 50 ms, 13 = 85 ms, 14 = 100 ms, 15 = 200 ms
  
  A millisecond is `TICKS_PER_MS` ticks and a tick is `TICK_CLKS` clocks. The measured delay lies within one tick period of the nominal value.
- R3: Every serial clock edge restarts the serial-clock timer. While chip select is inactive, the timer holds at zero and cannot expire.
- R4: The cycle after `spi_reset_o` pulses, `tmo_flag_o` is 1.
- R5: The link watchdog setting `wdt_cfg_i` maps 0 = 40 ms, 1 = 20 ms and 2 = 10 ms, each within one tick period. Setting 3 disables it, and `failsafe_req_o` then never pulses.
- R6: Each `frame_ok_i` pulse restarts the link watchdog. Valid frames that arrive more often than the window keep `failsafe_req_o` low.
- R7: Expiry of the link watchdog makes `failsafe_req_o` high for exactly one cycle, and the watchdog then starts a new window.
- R8: Chip select going inactive after at least one serial clock edge of a command, but before `cmd_done_i`, sets `cs_err_flag_o`. A release that follows `cmd_done_i`, or one with no clock edge at all, leaves it clear.
- R9: A serial-clock timeout discards the partial command, so releasing chip select after a timeout does not set `cs_err_flag_o`.
- R10: Both flags are sticky and clear on `clr_flags_i`. A new error event in the same cycle as the clear wins.
- R11: After reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_active_i | input | 1 | Chip select asserted (synchronised, active high) |
| sclk_edge_i | input | 1 | One-cycle pulse per serial clock edge |
| cmd_done_i | input | 1 | One-cycle pulse when a full command has been received |
| frame_ok_i | input | 1 | One-cycle pulse when a frame completes with valid CRC |
| rst_tmo_cfg_i | input | 4 | Serial-clock timeout setting |
| wdt_cfg_i | input | 2 | Link watchdog setting |
| clr_flags_i | input | 1 | Clear both sticky flags |
| spi_reset_o | output | 1 | One-cycle reset pulse to the SPI shift logic |
| failsafe_req_o | output | 1 | One-cycle request to enter the fail-safe state |
| tmo_flag_o | output | 1 | Sticky serial-clock timeout flag |
| cs_err_flag_o | output | 1 | Sticky chip-select abort flag |

## Verification
The bench builds the block with `TICK_CLKS` = 2 and `TICKS_PER_MS` = 4, so a half millisecond is four clocks. At these values every serial-clock setting can be measured, up to the longest at 1600 clocks, and so can all three watchdog windows. Each measured delay is checked against a window one tick period wide that is computed from the nominal value. The short tick also makes the restart cases practical to run: clock edges or valid frames arrive just inside a window, and the bench confirms that no pulse appears.

// File: rtl/spi_wdog_pkg.sv
package spi_wdog_pkg;

  // serial-clock timeout in half-millisecond units, 0 = off
  function automatic int unsigned rst_tmo_half_ms(input logic [3:0] cfg);
    case (cfg)
      4'h0: return 0;
      4'h1: return 1;
      4'h2: return 2;
      4'h3: return 4;
      4'h4: return 6;
      4'h5: return 8;
      4'h6: return 10;
      4'h7: return 20;
      4'h8: return 30;
      4'h9: return 40;
      4'hA: return 60;
      4'hB: return 80;
      4'hC: return 100;
      4'hD: return 170;
      4'hE: return 200;
      default: return 400;
    endcase
  endfunction

  // link watchdog in half-millisecond units, 0 = off
  function automatic int unsigned wdt_half_ms(input logic [1:0] cfg);
    case (cfg)
      2'd0: return 80;
      2'd1: return 40;
      2'd2: return 20;
      default: return 0;
    endcase
  endfunction

  localparam int unsigned MAX_HALF_MS = 400;

endpackage

// File: rtl/spi_wdog_tick.sv
module spi_wdog_tick #(
  parameter int unsigned TICK_CLKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CLKS > 2) ? $clog2(TICK_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  p_tick_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/spi_wdog_timer.sv
module spi_wdog_timer #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             hit;

  // >= tolerates a limit lowered mid-count
  assign hit = (cnt_q >= (limit_i - 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (restart_i || !en_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_i) begin
      if (hit) begin
        cnt_q <= '0;
        exp_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        exp_q <= 1'b0;
      end
    end else begin
      exp_q <= 1'b0;
    end
  end

  assign expire_o = exp_q;

  p_expire_needs_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(tick_i) && $past(en_i) && !$past(restart_i));

endmodule

// File: rtl/spi_wdog_cs_mon.sv
module spi_wdog_cs_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_active_i,
  input  logic sclk_edge_i,
  input  logic cmd_done_i,
  input  logic discard_i,
  output logic abort_o
);
  logic cs_prev_q;
  logic busy_q;
  logic busy_d;

  assign busy_d = (busy_q || (sclk_edge_i && cs_active_i))
                  && !(cmd_done_i || discard_i || !cs_active_i);
  assign abort_o = cs_prev_q && !cs_active_i && busy_q && !cmd_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      cs_prev_q <= cs_active_i;
      busy_q    <= busy_d;
    end
  end

  p_busy_needs_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> $past(cs_active_i));

endmodule

// File: rtl/spi_link_wdog.sv
module spi_link_wdog #(
  parameter int unsigned TICK_CLKS    = 50,
  parameter int unsigned TICKS_PER_MS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_active_i,
  input  logic       sclk_edge_i,
  input  logic       cmd_done_i,
  input  logic       frame_ok_i,
  input  logic [3:0] rst_tmo_cfg_i,
  input  logic [1:0] wdt_cfg_i,
  input  logic       clr_flags_i,
  output logic       spi_reset_o,
  output logic       failsafe_req_o,
  output logic       tmo_flag_o,
  output logic       cs_err_flag_o
);
  import spi_wdog_pkg::*;

  localparam int unsigned HALF_MS_TICKS = TICKS_PER_MS / 2;
  localparam int unsigned MAX_TICKS     = MAX_HALF_MS * HALF_MS_TICKS;
  localparam int unsigned CNT_W         = $clog2(MAX_TICKS + 1);

  logic             tick;
  logic             sclk_exp;
  logic             wdt_exp;
  logic             abort;
  logic [CNT_W-1:0] sclk_limit;
  logic [CNT_W-1:0] wdt_limit;
  logic             tmo_q;
  logic             cserr_q;

  assign sclk_limit = CNT_W'(rst_tmo_half_ms(rst_tmo_cfg_i) * HALF_MS_TICKS);
  assign wdt_limit  = CNT_W'(wdt_half_ms(wdt_cfg_i) * HALF_MS_TICKS);

  spi_wdog_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  spi_wdog_timer #(.CNT_W(CNT_W)) u_sclk_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (sclk_edge_i || !cs_active_i),
    .en_i      (rst_tmo_cfg_i != 4'h0),
    .limit_i   (sclk_limit),
    .expire_o  (sclk_exp)
  );

  spi_wdog_timer #(.CNT_W(CNT_W)) u_link_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (frame_ok_i),
    .en_i      (wdt_cfg_i != 2'd3),
    .limit_i   (wdt_limit),
    .expire_o  (wdt_exp)
  );

  spi_wdog_cs_mon u_cs_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_active_i (cs_active_i),
    .sclk_edge_i (sclk_edge_i),
    .cmd_done_i  (cmd_done_i),
    .discard_i   (sclk_exp),
    .abort_o     (abort)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q   <= 1'b0;
      cserr_q <= 1'b0;
    end else begin
      tmo_q   <= sclk_exp || (tmo_q && !clr_flags_i);
      cserr_q <= abort || (cserr_q && !clr_flags_i);
    end
  end

  assign spi_reset_o    = sclk_exp;
  assign failsafe_req_o = wdt_exp;
  assign tmo_flag_o     = tmo_q;
  assign cs_err_flag_o  = cserr_q;

  p_no_reset_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_tmo_cfg_i == 4'h0 && $past(rst_tmo_cfg_i) == 4'h0) |-> !spi_reset_o);

  p_reset_needs_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_reset_o |-> $past(cs_active_i) && !$past(sclk_edge_i));

  p_tmo_flag_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_reset_o |=> tmo_flag_o);

  p_fs_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_cfg_i == 2'd3 && $past(wdt_cfg_i) == 2'd3) |-> !failsafe_req_o);

  p_fs_after_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_ok_i) |-> !failsafe_req_o);

  p_fs_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_req_o |=> !failsafe_req_o);

  p_cserr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_err_flag_o) |-> !$past(cs_active_i));

  p_flags_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_o && !clr_flags_i) |=> tmo_flag_o);

endmodule

// File: tb/spi_link_wdog_tb.sv
module spi_link_wdog_tb;
  localparam int unsigned TCLK = 2;
  localparam int unsigned TPMS = 4;
  localparam int unsigned HMT  = TPMS / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, sedge = 1'b0, cdone = 1'b0, fok = 1'b0, clr = 1'b0;
  logic [3:0] rcfg = 4'h0;
  logic [1:0] wcfg = 2'd3;
  logic       srst, fsreq, tflag, cflag;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_link_wdog #(.TICK_CLKS(TCLK), .TICKS_PER_MS(TPMS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_active_i(cs), .sclk_edge_i(sedge),
    .cmd_done_i(cdone), .frame_ok_i(fok), .rst_tmo_cfg_i(rcfg),
    .wdt_cfg_i(wcfg), .clr_flags_i(clr), .spi_reset_o(srst),
    .failsafe_req_o(fsreq), .tmo_flag_o(tflag), .cs_err_flag_o(cflag)
  );

  function automatic int hm_rst(input int c);
    int t[16] = '{0, 1, 2, 4, 6, 8, 10, 20, 30, 40, 60, 80, 100, 170, 200, 400};
    return t[c];
  endfunction

  function automatic int hm_wdt(input int c);
    return (c == 0) ? 80 : (c == 1) ? 40 : (c == 2) ? 20 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flags();
    clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
  endtask

  // count negedges until the chosen output is seen high
  task automatic wait_pulse(input bit fs, input int maxc, output int n);
    n = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if ((fs ? fsreq : srst) === 1'b1) begin n = i; break; end
    end
  endtask

  task automatic t_reset();
    check(srst === 1'b0 && fsreq === 1'b0, "R11 pulses", int'(srst) + int'(fsreq), 0);
    check(tflag === 1'b0 && cflag === 1'b0, "R11 flags", int'(tflag) + int'(cflag), 0);
  endtask

  task automatic t_sclk_table();
    int cfgs[5] = '{1, 4, 7, 10, 15};
    foreach (cfgs[k]) begin
      int l, n, lo, hi;
      l  = hm_rst(cfgs[k]) * HMT;
      lo = (l - 1) * TCLK;
      hi = l * TCLK + 2;
      rcfg = 4'(cfgs[k]); cs = 1'b0; idle(2); clear_flags();
      cs = 1'b1; sedge = 1'b1; @(negedge clk); sedge = 1'b0;
      wait_pulse(1'b0, hi + 4, n);
      n++;
      check(n >= lo && n <= hi, $sformatf("R2 cfg %0d delay", cfgs[k]), n, l * TCLK);
      @(negedge clk);
      check(srst === 1'b0, "R2 one-cycle", int'(srst), 0);
      check(tflag === 1'b1, "R4 flag", int'(tflag), 1);
      cs = 1'b0; idle(2);
    end
  endtask

  task automatic t_sclk_off();
    int n;
    rcfg = 4'h0; clear_flags();
    cs = 1'b1; wait_pulse(1'b0, 2000, n); cs = 1'b0;
    check(n == 0, "R1 no reset pulse", n, 0);
    check(tflag === 1'b0, "R1 no flag", int'(tflag), 0);
  endtask

  task automatic t_sclk_restart();
    int hits = 0;
    rcfg = 4'h2; clear_flags(); // 8 clocks window
    cs = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sedge = 1'b1; @(negedge clk); sedge = 1'b0;
      for (int j = 0; j < 4; j++) begin @(negedge clk); if (srst) hits++; end
    end
    cs = 1'b0;
    check(hits == 0, "R3 edges restart", hits, 0);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (srst) hits++; end
    check(hits == 0 && tflag === 1'b0, "R3 cs inactive holds", hits, 0);
  endtask

  task automatic t_clear();
    rcfg = 4'h1; cs = 1'b1; idle(20); cs = 1'b0; rcfg = 4'h0; idle(2);
    check(tflag === 1'b1, "R10 flag set before clear", int'(tflag), 1);
    idle(10);
    check(tflag === 1'b1, "R10 sticky", int'(tflag), 1);
    clear_flags();
    check(tflag === 1'b0, "R10 cleared", int'(tflag), 0);
  endtask

  task automatic t_wdt_table();
    for (int c = 0; c < 3; c++) begin
      int l, n, lo, hi;
      l  = hm_wdt(c) * HMT;
      lo = (l - 1) * TCLK;
      hi = l * TCLK + 2;
      wcfg = 2'(c);
      fok = 1'b1; @(negedge clk); fok = 1'b0;
      wait_pulse(1'b1, hi + 4, n);
      n++;
      check(n >= lo && n <= hi, $sformatf("R5 cfg %0d delay", c), n, l * TCLK);
      @(negedge clk);
      check(fsreq === 1'b0, "R7 one-cycle request", int'(fsreq), 0);
      wait_pulse(1'b1, hi + 4, n);
      check(n >= lo - 2 && n <= hi, "R7 new window", n, l * TCLK);
    end
  endtask

  task automatic t_wdt_off();
    int n;
    wcfg = 2'd3; @(negedge clk);
    wait_pulse(1'b1, 1000, n);
    check(n == 0, "R5 disabled", n, 0);
  endtask

  task automatic t_wdt_restart();
    int hits = 0;
    wcfg = 2'd2; // 80 clocks window
    for (int i = 0; i < 12; i++) begin
      fok = 1'b1; @(negedge clk); fok = 1'b0;
      for (int j = 0; j < 60; j++) begin @(negedge clk); if (fsreq) hits++; end
    end
    check(hits == 0, "R6 frames keep link alive", hits, 0);
    wcfg = 2'd3;
  endtask

  task automatic t_cs_abort();
    rcfg = 4'h0; clear_flags();
    cs = 1'b1; @(negedge clk); sedge = 1'b1; @(negedge clk); sedge = 1'b0;
    idle(2); cs = 1'b0; idle(2);
    check(cflag === 1'b1, "R8 abort mid-command", int'(cflag), 1);
    clear_flags();
    check(cflag === 1'b0, "R10 cs flag cleared", int'(cflag), 0);
    cs = 1'b1; @(negedge clk); sedge = 1'b1; @(negedge clk); sedge = 1'b0;
    cdone = 1'b1; @(negedge clk); cdone = 1'b0; cs = 1'b0; idle(2);
    check(cflag === 1'b0, "R8 release after done", int'(cflag), 0);
    cs = 1'b1; idle(3); cs = 1'b0; idle(2);
    check(cflag === 1'b0, "R8 release with no edge", int'(cflag), 0);
  endtask

  task automatic t_discard();
    int n;
    rcfg = 4'h1; clear_flags();
    cs = 1'b1; sedge = 1'b1; @(negedge clk); sedge = 1'b0;
    wait_pulse(1'b0, 20, n);
    @(negedge clk); cs = 1'b0; rcfg = 4'h0; idle(2);
    check(tflag === 1'b1, "R9 timeout seen", int'(tflag), 1);
    check(cflag === 1'b0, "R9 no cs error after timeout", int'(cflag), 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_sclk_table();
    t_sclk_off();
    t_sclk_restart();
    t_clear();
    t_wdt_table();
    t_wdt_off();
    t_wdt_restart();
    t_cs_abort();
    t_discard();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule